// File: doc/BRIEF.md
# Byte-Wide Flash Program and Erase Sequencer

This controller sits on the host side of a parallel, byte-wide flash device that needs an externally timed high-voltage pulse for every change to its contents. A request port accepts one job at a time, either a single-byte program or a whole-array erase. The controller then issues the device's command write cycles and measures each pulse with its own cycle counter. It reads the verify data back, compares it and retries a bounded number of times. At the end it reports a one-cycle done pulse together with a pass flag and, on failure, the address that failed.

For an erase, the controller first brings every byte to 00h using the same program loop. It then sends the erase command twice, waits out the erase pulse and checks the array one byte at a time against FFh in ascending address order. If a byte does not read back as FFh, the whole array is pulsed again and checking resumes at that same byte. Command opcodes, pulse lengths (given in microseconds, with a clock-rate parameter) and both retry limits are parameters.

Top module: `flash_seq`

## Requirements
- R1: A program job writes the program-setup opcode, then writes the request data at the request address, then writes the program-verify opcode, then pulses `dev_oe` at that address. It compares the byte returned on `dev_rdata` in the following cycle with the request data.
- R2: Between the program data write and the program-verify write there are exactly `PROG_US*(CLK_HZ/1e6)` cycles with neither `dev_we` nor `dev_oe` high.
- R3: On a program mismatch, the whole three-write sequence repeats. After `PROG_TRIES` attempts in total without a match, the job ends with `pass`=0 and `fail_addr` equal to the byte's address.
- R4: An erase job first programs every address from 0 to 2^ADDR_W-1 to 00h, using the R1/R3 loop. No erase command is written until every byte has verified as 00h. A byte that fails preprogramming ends the job with `pass`=0 and `fail_addr` set to that byte.
- R5: An erase pulse is started by two consecutive erase-opcode writes. Exactly `ERASE_US*(CLK_HZ/1e6)` idle cycles follow, then an erase-verify opcode write that carries an array address.
- R6: Erase verify starts at address 0 and compares each read byte with FFh. After a good compare it writes erase-verify again at the next address. A good compare at the last address ends the job with `pass`=1.
- R7: On an erase-verify mismatch, the erase pulse sequence (R5) repeats and verification resumes at the failing address. After `ERASE_TRIES` erase pulses without success, the job ends with `pass`=0 and `fail_addr` set to the failing address.
- R8: `busy` rises the cycle after an accepted `start`. `done` is high for exactly one cycle, and in that cycle `busy` is already low. A `start` while busy is ignored.
- R9: After reset, `busy`, `done`, `dev_we` and `dev_oe` are all low.
- R10: `dev_we` and `dev_oe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| op | input | 1 | Job kind: 0 program byte, 1 erase array |
| req_addr | input | ADDR_W | Byte address for a program job |
| req_data | input | 8 | Byte value for a program job |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle job completion pulse |
| pass | output | 1 | Result of the last job, valid with done |
| fail_addr | output | ADDR_W | Address that failed, valid with done when pass is 0 |
| dev_we | output | 1 | Device write strobe, one cycle per command write |
| dev_oe | output | 1 | Device read strobe, data returns the next cycle |
| dev_addr | output | ADDR_W | Device address for writes and reads |
| dev_wdata | output | 8 | Device write data (opcode or byte) |
| dev_rdata | input | 8 | Device read data, one cycle after dev_oe |

## Verification
The bench's device model has cells that need several pulses before they change. It targets the retry limit in both directions: one retry fewer than the limit must pass and one more must fail. An off-by-one counter would pass a byte it should fail, or give up too early. A weak cell in the middle of the array shows whether erase verification restarts from zero (extra verify writes) or skips the failing byte (a wrong pass). The model counts idle cycles before each verify write, so a pulse one cycle short or long is caught. It also reports an erase command that arrives while any byte is still nonzero.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t ERASED = 8'hFF;
    localparam byte_t ZEROED = 8'h00;

    typedef enum logic {
        JOB_PROG  = 1'b0,
        JOB_ERASE = 1'b1
    } job_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PSET,
        S_PWR,
        S_PPULSE,
        S_PVER,
        S_PRD,
        S_PCMP,
        S_ESET,
        S_EGO,
        S_EPULSE,
        S_EVER,
        S_ERD,
        S_ECMP
    } seq_state_e;

    typedef struct packed {
        logic  we;
        logic  oe;
        byte_t wdata;
    } bus_drive_t;

    function automatic int pulse_cycles(input int clk_hz, input int us);
        int c;
        c = (clk_hz / 1_000_000) * us;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2 / R5: the count never passes the pulse length
    p_pulse_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R2: the pulse cannot end on its first cycle unless it is one cycle long
    p_pulse_len_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !$past(run) && CYCLES > 1) |-> !expired);

endmodule

// File: rtl/flash_seq_retry.sv
module flash_seq_retry #(
    parameter int LIMIT = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bump,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] FINAL = CW'(LIMIT - 1);

    logic [CW-1:0] tries;

    assign last = (tries == FINAL);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tries <= '0;
        end else if (bump) begin
            tries <= tries + 1'b1;
        end
    end

    // R3 / R7: attempts never exceed the configured limit
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        tries <= FINAL);

    // R3 / R7: a further attempt is never requested after the final one
    p_no_bump_past_r7: assert property (@(posedge clk) disable iff (rst)
        (bump && !clr) |-> !last);

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int    ADDR_W      = 18,
    parameter int    CLK_HZ      = 100_000_000,
    parameter int    PROG_US     = 10,
    parameter int    ERASE_US    = 10_000,
    parameter int    PROG_TRIES  = 25,
    parameter int    ERASE_TRIES = 1000,
    parameter byte_t OPC_PSETUP  = 8'h4A,
    parameter byte_t OPC_PVERIFY = 8'hC5,
    parameter byte_t OPC_ERASE   = 8'h2D,
    parameter byte_t OPC_EVERIFY = 8'hA3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              dev_we,
    output logic              dev_oe,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [7:0]        dev_wdata,
    input  logic [7:0]        dev_rdata
);
    localparam int PROG_CYC  = pulse_cycles(CLK_HZ, PROG_US);
    localparam int ERASE_CYC = pulse_cycles(CLK_HZ, ERASE_US);
    localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

    seq_state_e        st;
    job_e              job;
    logic [ADDR_W-1:0] cur_addr;
    byte_t             cur_data;
    bus_drive_t        drv;

    logic accept;
    logic p_exp, e_exp;
    logic p_last, e_last;
    logic p_match, e_match;
    logic p_clr, p_bump, e_clr, e_bump;

    assign accept  = start && (st == S_IDLE);
    assign p_match = (dev_rdata == cur_data);
    assign e_match = (dev_rdata == ERASED);
    assign p_clr   = accept || ((st == S_PCMP) && p_match);
    assign p_bump  = (st == S_PCMP) && !p_match && !p_last;
    assign e_clr   = accept;
    assign e_bump  = (st == S_ECMP) && !e_match && !e_last;

    flash_seq_timer #(.CYCLES(PROG_CYC)) u_ptimer (
        .clk(clk), .rst(rst), .run(st == S_PPULSE), .expired(p_exp));

    flash_seq_timer #(.CYCLES(ERASE_CYC)) u_etimer (
        .clk(clk), .rst(rst), .run(st == S_EPULSE), .expired(e_exp));

    flash_seq_retry #(.LIMIT(PROG_TRIES)) u_pretry (
        .clk(clk), .rst(rst), .clr(p_clr), .bump(p_bump), .last(p_last));

    flash_seq_retry #(.LIMIT(ERASE_TRIES)) u_eretry (
        .clk(clk), .rst(rst), .clr(e_clr), .bump(e_bump), .last(e_last));

    // bus drive decoded from the sequencer state
    always_comb begin
        drv = '{we: 1'b0, oe: 1'b0, wdata: ZEROED};
        unique case (st)
            S_PSET: drv = '{we: 1'b1, oe: 1'b0, wdata: OPC_PSETUP};
            S_PWR:  drv = '{we: 1'b1, oe: 1'b0, wdata: cur_data};
            S_PVER: drv = '{we: 1'b1, oe: 1'b0, wdata: OPC_PVERIFY};
            S_ESET, S_EGO:
                    drv = '{we: 1'b1, oe: 1'b0, wdata: OPC_ERASE};
            S_EVER: drv = '{we: 1'b1, oe: 1'b0, wdata: OPC_EVERIFY};
            S_PRD, S_ERD:
                    drv = '{we: 1'b0, oe: 1'b1, wdata: ZEROED};
            default: ;
        endcase
    end

    assign dev_we    = drv.we;
    assign dev_oe    = drv.oe;
    assign dev_wdata = drv.wdata;
    assign dev_addr  = cur_addr;
    assign busy      = (st != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            job       <= JOB_PROG;
            cur_addr  <= '0;
            cur_data  <= ZEROED;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail_addr <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        job <= job_e'(op);
                        st  <= S_PSET;
                        if (job_e'(op) == JOB_ERASE) begin
                            cur_addr <= '0;
                            cur_data <= ZEROED;
                        end else begin
                            cur_addr <= req_addr;
                            cur_data <= req_data;
                        end
                    end
                end
                S_PSET:   st <= S_PWR;
                S_PWR:    st <= S_PPULSE;
                S_PPULSE: if (p_exp) st <= S_PVER;
                S_PVER:   st <= S_PRD;
                S_PRD:    st <= S_PCMP;
                S_PCMP: begin
                    if (p_match) begin
                        if (job == JOB_PROG) begin
                            st   <= S_IDLE;
                            done <= 1'b1;
                            pass <= 1'b1;
                        end else if (cur_addr == ADDR_TOP) begin
                            cur_addr <= '0;
                            st       <= S_ESET;
                        end else begin
                            cur_addr <= cur_addr + 1'b1;
                            st       <= S_PSET;
                        end
                    end else if (p_last) begin
                        st        <= S_IDLE;
                        done      <= 1'b1;
                        pass      <= 1'b0;
                        fail_addr <= cur_addr;
                    end else begin
                        st <= S_PSET;
                    end
                end
                S_ESET:   st <= S_EGO;
                S_EGO:    st <= S_EPULSE;
                S_EPULSE: if (e_exp) st <= S_EVER;
                S_EVER:   st <= S_ERD;
                S_ERD:    st <= S_ECMP;
                S_ECMP: begin
                    if (e_match) begin
                        if (cur_addr == ADDR_TOP) begin
                            st   <= S_IDLE;
                            done <= 1'b1;
                            pass <= 1'b1;
                        end else begin
                            cur_addr <= cur_addr + 1'b1;
                            st       <= S_EVER;
                        end
                    end else if (e_last) begin
                        st        <= S_IDLE;
                        done      <= 1'b1;
                        pass      <= 1'b0;
                        fail_addr <= cur_addr;
                    end else begin
                        st <= S_ESET;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R10: never write and read the device together
    p_bus_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(dev_we && dev_oe));

    // R8: done lasts a single cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done appears as busy drops
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R8: busy only rises because of a start request
    p_busy_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R7: a retried erase keeps the failing address
    p_erase_resume_r7: assert property (@(posedge clk) disable iff (rst)
        (st == S_ECMP && !e_match && !e_last) |=> (st == S_ESET && $stable(cur_addr)));

    // R4: erase commands are only written once preprogramming reached the top address
    p_preprog_done_r4: assert property (@(posedge clk) disable iff (rst)
        (st == S_ESET && $past(st) == S_PCMP) |-> $past(cur_addr) == ADDR_TOP);

endmodule

// File: tb/flash_seq_test.sv
module flash_seq_test;
    localparam int AW = 4;
    localparam int NB = 1 << AW;
    localparam int PCYC = 10;
    localparam int ECYC = 25;
    localparam int PTRY = 3;
    localparam int ETRY = 4;
    localparam logic [7:0] C_PS = 8'h4A, C_PV = 8'hC5, C_ER = 8'h2D, C_EV = 8'hA3;

    logic clk = 0, rst = 1, start = 0, op = 0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic busy, done, pass, dev_we, dev_oe;
    logic [AW-1:0] fail_addr, dev_addr;
    logic [7:0] dev_wdata, dev_rdata;

    always #4 clk = ~clk;

    flash_seq #(.ADDR_W(AW), .CLK_HZ(1_000_000), .PROG_US(PCYC), .ERASE_US(ECYC),
        .PROG_TRIES(PTRY), .ERASE_TRIES(ETRY), .OPC_PSETUP(C_PS), .OPC_PVERIFY(C_PV),
        .OPC_ERASE(C_ER), .OPC_EVERIFY(C_EV)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .req_addr(req_addr),
        .req_data(req_data), .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr),
        .dev_we(dev_we), .dev_oe(dev_oe), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata));

    // behavioural device model
    logic [7:0] mem [NB];
    int prog_left [NB];
    int erase_left [NB];
    int mstate = 0;
    int cyc = 0, last_cyc = 0, last_kind = 0;
    int n_pwr = 0, n_epulse = 0, n_ever = 0, gap_err = 0, seq_err = 0;
    int preprog_err = 0, order_err = 0, ev_prev = 0;
    bit ev_first = 1, pulsed = 0, oe_dbl = 0;
    logic [7:0] rd_q = 8'h00;
    assign dev_rdata = rd_q;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (dev_oe) rd_q <= mem[dev_addr];
        if (dev_we && dev_oe) oe_dbl = 1;
        if (dev_we) begin
            if (mstate == 1) begin
                n_pwr++;
                if (prog_left[dev_addr] > 1) prog_left[dev_addr]--;
                else mem[dev_addr] = mem[dev_addr] & dev_wdata;
                mstate = 0; last_kind = 1; last_cyc = cyc;
            end else if (dev_wdata == C_PS) begin
                mstate = 1; last_kind = 0;
            end else if (dev_wdata == C_ER) begin
                if (mstate == 2) begin
                    if (n_epulse == 0)
                        for (int a = 0; a < NB; a++) if (mem[a] != 8'h00) preprog_err++;
                    n_epulse++; pulsed = 1;
                    for (int a = 0; a < NB; a++)
                        if (erase_left[a] > 1) erase_left[a]--; else mem[a] = 8'hFF;
                    mstate = 0; last_kind = 2; last_cyc = cyc;
                end else begin
                    mstate = 2; last_kind = 0;
                end
            end else if (dev_wdata == C_PV) begin
                if (last_kind != 1) seq_err++;
                else if (cyc - last_cyc != PCYC + 1) gap_err++;
                mstate = 0; last_kind = 0;
            end else if (dev_wdata == C_EV) begin
                n_ever++;
                if (last_kind == 2 && cyc - last_cyc != ECYC + 1) gap_err++;
                if (ev_first) begin
                    if (dev_addr != 0) order_err++;
                end else if (!((pulsed && int'(dev_addr) == ev_prev) || int'(dev_addr) == ev_prev + 1))
                    order_err++;
                ev_first = 0; pulsed = 0; ev_prev = int'(dev_addr);
                mstate = 0; last_kind = 3;
            end else begin
                seq_err++;
            end
        end
    end

    int checks = 0, fails = 0;
    logic got_pass;
    logic [AW-1:0] got_fa;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear(input logic [7:0] fill);
        for (int a = 0; a < NB; a++) begin
            mem[a] = fill; prog_left[a] = 1; erase_left[a] = 1;
        end
        n_pwr = 0; n_epulse = 0; n_ever = 0; gap_err = 0; seq_err = 0;
        preprog_err = 0; order_err = 0; ev_first = 1; pulsed = 0;
    endtask

    task automatic kick(input logic o, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        start = 1; op = o; req_addr = a; req_data = d;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk); n++;
        end
        got_pass = pass; got_fa = fail_addr;
        chk(done == 1'b1, "R8 done seen", int'(done), 1);
        chk(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 7) ^ (a << 4));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        model_clear(8'hFF);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        chk(!busy && !done && !dev_we && !dev_oe, "R9 reset outputs", int'({busy, done, dev_we, dev_oe}), 0);

        // R1 R2 basic program
        kick(1'b0, 4'd3, 8'hA5);
        chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        wait_done();
        chk(got_pass == 1'b1, "R1 program pass", int'(got_pass), 1);
        chk(mem[3] == 8'hA5, "R1 byte written", int'(mem[3]), 'hA5);
        chk(n_pwr == 1, "R1 single program write", n_pwr, 1);
        chk(seq_err == 0 && gap_err == 0, "R2 program pulse gap", gap_err + seq_err, 0);

        // R1 sweep over every address
        model_clear(8'hFF);
        for (int a = 0; a < NB; a++) begin
            kick(1'b0, AW'(a), pat(a));
            wait_done();
            chk(got_pass == 1'b1 && mem[a] == pat(a), "R1 sweep", int'(mem[a]), int'(pat(a)));
        end
        chk(gap_err == 0 && seq_err == 0, "R2 sweep gaps", gap_err + seq_err, 0);

        // R3 one retry short of the limit passes
        model_clear(8'hFF);
        prog_left[5] = PTRY;
        kick(1'b0, 4'd5, 8'h3C);
        wait_done();
        chk(got_pass == 1'b1, "R3 pass on last try", int'(got_pass), 1);
        chk(n_pwr == PTRY, "R3 attempt count", n_pwr, PTRY);

        // R3 beyond the limit fails
        model_clear(8'hFF);
        prog_left[6] = PTRY + 2;
        kick(1'b0, 4'd6, 8'h81);
        wait_done();
        chk(got_pass == 1'b0, "R3 fail beyond limit", int'(got_pass), 0);
        chk(got_fa == 4'd6, "R3 fail address", int'(got_fa), 6);
        chk(n_pwr == PTRY, "R3 attempts capped", n_pwr, PTRY);

        // R3 bit that cannot be set back
        model_clear(8'hFF);
        mem[7] = 8'h00;
        kick(1'b0, 4'd7, 8'h0F);
        wait_done();
        chk(got_pass == 1'b0 && got_fa == 4'd7, "R3 unprogrammable byte", int'(got_fa), 7);

        // R4 R5 R6 R7 erase with a weak cell
        model_clear(8'hFF);
        for (int a = 0; a < NB; a++) mem[a] = pat(a + 3);
        erase_left[9] = 3;
        kick(1'b1, 4'd0, 8'h00);
        wait_done();
        chk(got_pass == 1'b1, "R6 erase pass", int'(got_pass), 1);
        chk(preprog_err == 0, "R4 preprogram before erase", preprog_err, 0);
        chk(n_pwr == NB, "R4 one preprogram per byte", n_pwr, NB);
        chk(n_epulse == 3, "R7 erase pulses", n_epulse, 3);
        chk(n_ever == NB + 2, "R7 resume at failing byte", n_ever, NB + 2);
        chk(order_err == 0, "R6 verify order", order_err, 0);
        chk(gap_err == 0 && seq_err == 0, "R5 erase pulse gap", gap_err + seq_err, 0);
        begin
            int nff = 0;
            for (int a = 0; a < NB; a++) if (mem[a] == 8'hFF) nff++;
            chk(nff == NB, "R6 array erased", nff, NB);
        end

        // R7 erase fails after the limit
        model_clear(8'h00);
        erase_left[12] = ETRY + 2;
        kick(1'b1, 4'd0, 8'h00);
        wait_done();
        chk(got_pass == 1'b0 && got_fa == 4'd12, "R7 erase fail address", int'(got_fa), 12);
        chk(n_epulse == ETRY, "R7 erase pulse cap", n_epulse, ETRY);

        // R4 preprogram failure stops before any erase
        model_clear(8'hFF);
        prog_left[2] = PTRY + 4;
        kick(1'b1, 4'd0, 8'h00);
        wait_done();
        chk(got_pass == 1'b0 && got_fa == 4'd2, "R4 preprogram fail", int'(got_fa), 2);
        chk(n_epulse == 0, "R4 no erase after preprogram fail", n_epulse, 0);

        // R8 start while busy ignored
        model_clear(8'hFF);
        kick(1'b0, 4'd1, 8'h5A);
        repeat (4) @(negedge clk);
        start = 1; op = 1; req_addr = 4'd9; req_data = 8'h00;
        @(negedge clk);
        start = 0;
        wait_done();
        repeat (5) @(negedge clk);
        chk(got_pass == 1'b1 && mem[1] == 8'h5A, "R8 job unaffected", int'(mem[1]), 'h5A);
        chk(busy == 1'b0 && n_epulse == 0 && mem[9] == 8'hFF, "R8 extra start ignored", n_epulse, 0);
        chk(oe_dbl == 0, "R10 strobes exclusive", int'(oe_dbl), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule